// File: doc/BRIEF.md
# Standby Clock and Bus Pin Control

This block is the power-management register unit of a microcontroller. It holds an 8-bit control byte with three live fields: a stop bit for the system clock output pin and two module standby selects, one for each on-chip serial interface. Each module standby select gates that module's clock enable. A second byte, the bus-hold configuration, holds one bit. That bit decides how the external address bus and the bus strobes behave while the chip is in software standby.

Both bytes return to their initial values on system reset and whenever hardware standby is asserted. Software standby leaves them untouched. Outside software standby the pin controls simply pass the normal bus interface drive signals through. In software standby the pins either float, or the address is frozen and every strobe is driven high. The bus-hold bit picks which.

Top module: `stby_ctl`

## Requirements
- R1: After reset the control byte reads 0x78, the configuration byte reads 0x00, `clkOutEn` is 1 and `modStby` is 0.
- R2: Bit 7 of the control byte stops the clock output pin. Writing 1 makes `clkOutEn` 0 on the clock edge after the write, and writing 0 makes it 1.
- R3: Control byte bits 1 and 0 drive `modStby[1]` and `modStby[0]`. A 1 places that serial module in standby. Each takes effect on the clock edge after the write.
- R4: Control byte bits 6 to 3 always read 1 and bit 2 always reads 0. Writes to these bits are ignored.
- R5: While `hwStby` is 1, both bytes return to their reset values at every clock edge, and a write in the same cycle is ignored.
- R6: While `swStby` is 1, both bytes keep their contents, and writes are ignored.
- R7: Configuration byte (`regSel`=1) bit 1 is the bus-hold bit. All other bits of that byte read 0.
- R8: With `swStby` at 1 and the bus-hold bit at 0, `addrOe` is 0 and every bit of `strbOe` is 0.
- R9: With `swStby` at 1 and the bus-hold bit at 1, `addrOut` shows the `busAddr` value from the last cycle before standby was entered. It stays there while standby lasts. `addrOe` is 1, and `strbOut` and `strbOe` are all ones.
- R10: With `swStby` at 0, `addrOut`, `addrOe`, `strbOut` and `strbOe` equal `busAddr`, `busAddrOe`, `strbIn` and `strbOeIn`, whatever the bus-hold bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwStby | input | 1 | Hardware standby indication |
| swStby | input | 1 | Software standby indication |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control byte, 1 selects the configuration byte |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected byte |
| clkOutEn | output | 1 | System clock output pin enable |
| modStby | output | 2 | Serial module standby (clock-enable gate), bit n for module n |
| busAddr | input | ADDR_W | Address from the bus interface |
| busAddrOe | input | 1 | Address output enable from the bus interface |
| strbIn | input | STRB_W | Strobe levels from the bus interface |
| strbOeIn | input | STRB_W | Strobe output enables from the bus interface |
| addrOut | output | ADDR_W | Address to the pads |
| addrOe | output | 1 | Address pad output enable |
| strbOut | output | STRB_W | Strobe levels to the pads |
| strbOe | output | STRB_W | Strobe pad output enables |

## Verification
Two pairs of events can meet in one cycle. A register write can land in the same cycle as hardware standby. The bench asserts `wrEn` with a new value and raises `hwStby` in the same cycle, then expects the reset values rather than the written ones. Entry into software standby can also land in the same cycle as a change on `busAddr`. The bench raises `swStby` and changes `busAddr` together, then expects the pads to keep the address from the cycle before. A write issued during software standby is judged by reading the byte back after exit.

// File: rtl/stby_ctl_pkg.sv
package stby_ctl_pkg;
  localparam int MOD_N = 2;
  localparam logic [7:0] CTL_INIT = 8'h78;

  typedef struct packed {
    logic ctlWr;
    logic cfgWr;
    logic regInit;
    logic addrTrack;
    logic busHold;
  } stby_strb_t;
endpackage

// File: rtl/stby_ctl_ctrl.sv
module stby_ctl_ctrl
  import stby_ctl_pkg::*;
(
  input  logic       hwStby,
  input  logic       swStby,
  input  logic       wrEn,
  input  logic       regSel,
  output stby_strb_t strb
);
  logic wrOk;

  always_comb begin
    wrOk           = wrEn && !hwStby && !swStby;
    strb.ctlWr     = wrOk && !regSel;
    strb.cfgWr     = wrOk && regSel;
    strb.regInit   = hwStby;
    strb.addrTrack = !swStby;
    strb.busHold   = swStby;
  end
endmodule

// File: rtl/stby_ctl_dp.sv
module stby_ctl_dp
  import stby_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STRB_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  stby_strb_t        strb,
  input  logic              regSel,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              clkOutEn,
  output logic [MOD_N-1:0]  modStby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busAddrOe,
  input  logic [STRB_W-1:0] strbIn,
  input  logic [STRB_W-1:0] strbOeIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [STRB_W-1:0] strbOut,
  output logic [STRB_W-1:0] strbOe
);
  logic              clkStop;
  logic [MOD_N-1:0]  modSel;
  logic              holdEn;
  logic [ADDR_W-1:0] holdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkStop <= CTL_INIT[7];
      modSel  <= CTL_INIT[MOD_N-1:0];
      holdEn  <= 1'b0;
    end else if (strb.regInit) begin
      clkStop <= CTL_INIT[7];
      modSel  <= CTL_INIT[MOD_N-1:0];
      holdEn  <= 1'b0;
    end else begin
      if (strb.ctlWr) begin
        clkStop <= wrData[7];
        modSel  <= wrData[MOD_N-1:0];
      end
      if (strb.cfgWr) holdEn <= wrData[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdAddr <= '0;
    else if (strb.addrTrack) holdAddr <= busAddr;
  end

  always_comb begin
    if (regSel) rdData = {6'b0, holdEn, 1'b0};
    else        rdData = {clkStop, CTL_INIT[6:3], 1'b0, modSel};
  end

  assign clkOutEn = !clkStop;
  assign modStby  = modSel;

  always_comb begin
    if (!strb.busHold) begin
      addrOut = busAddr;
      addrOe  = busAddrOe;
      strbOut = strbIn;
      strbOe  = strbOeIn;
    end else if (holdEn) begin
      addrOut = holdAddr;
      addrOe  = 1'b1;
      strbOut = '1;
      strbOe  = '1;
    end else begin
      addrOut = holdAddr;
      addrOe  = 1'b0;
      strbOut = '1;
      strbOe  = '0;
    end
  end

  // R2
  clk_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlWr |=> clkOutEn == !$past(wrData[7]));
  // R3
  mod_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlWr |=> modStby == $past(wrData[MOD_N-1:0]));
  // R5
  hw_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.regInit |=> (clkOutEn && modStby == '0 && !holdEn));
  // R6
  sw_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busHold && !strb.regInit) |=> ($stable(clkStop) && $stable(modSel) && $stable(holdEn)));
  // R8
  tri_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busHold && !holdEn) |-> (!addrOe && strbOe == '0));
  // R9
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busHold && $past(strb.busHold) && holdEn) |-> $stable(addrOut));
  // R10
  pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busHold |-> (addrOut == busAddr && addrOe == busAddrOe));
endmodule

// File: rtl/stby_ctl.sv
module stby_ctl
  import stby_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STRB_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStby,
  input  logic              swStby,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              clkOutEn,
  output logic [1:0]        modStby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busAddrOe,
  input  logic [STRB_W-1:0] strbIn,
  input  logic [STRB_W-1:0] strbOeIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [STRB_W-1:0] strbOut,
  output logic [STRB_W-1:0] strbOe
);
  stby_strb_t strb;

  stby_ctl_ctrl u_ctrl (
    .hwStby (hwStby),
    .swStby (swStby),
    .wrEn   (wrEn),
    .regSel (regSel),
    .strb   (strb)
  );

  stby_ctl_dp #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regSel    (regSel),
    .wrData    (wrData),
    .rdData    (rdData),
    .clkOutEn  (clkOutEn),
    .modStby   (modStby),
    .busAddr   (busAddr),
    .busAddrOe (busAddrOe),
    .strbIn    (strbIn),
    .strbOeIn  (strbOeIn),
    .addrOut   (addrOut),
    .addrOe    (addrOe),
    .strbOut   (strbOut),
    .strbOe    (strbOe)
  );
endmodule

// File: tb/stby_ctl_tb.sv
module stby_ctl_tb;
  localparam int AW = 16;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hwStby = 1'b0, swStby = 1'b0, wrEn = 1'b0, regSel = 1'b0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdData;
  logic          clkOutEn;
  logic [1:0]    modStby;
  logic [AW-1:0] busAddr = '0;
  logic          busAddrOe = 1'b0;
  logic [SW-1:0] strbIn = '0, strbOeIn = '0;
  logic [AW-1:0] addrOut;
  logic          addrOe;
  logic [SW-1:0] strbOut, strbOe;

  always #2.5 clk = !clk;

  stby_ctl #(.ADDR_W(AW), .STRB_W(SW)) u_dut (.*);

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t scq[$];
  int    nChk = 0;
  int    nErr = 0;
  bit    done = 0;

  // selectors: 0 rdData, 1 clkOutEn, 2 modStby, 3 addrOut, 4 addrOe, 5 strbOut, 6 strbOe
  task automatic expect_val(input string req, input int sel, input logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    scq.push_back(it);
  endtask

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      0: return 32'(rdData);
      1: return 32'(clkOutEn);
      2: return 32'(modStby);
      3: return 32'(addrOut);
      4: return 32'(addrOe);
      5: return 32'(strbOut);
      default: return 32'(strbOe);
    endcase
  endfunction

  always @(negedge clk) begin
    while (scq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = scq.pop_front();
      act = observe(it.sel);
      nChk++;
      if (act !== it.exp) begin
        nErr++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    // R1
    regSel = 0; expect_val("R1", 0, 32'h78);
    expect_val("R1", 1, 1); expect_val("R1", 2, 0);
    step();
    regSel = 1; expect_val("R1", 0, 32'h00);
    step();
    // R2 R3 R4
    wr(0, 8'hFF); regSel = 0;
    expect_val("R4", 0, 32'hFB); expect_val("R2", 1, 0); expect_val("R3", 2, 3);
    step();
    wr(0, 8'h00);
    expect_val("R4", 0, 32'h78); expect_val("R2", 1, 1); expect_val("R3", 2, 0);
    step();
    wr(0, 8'h01); expect_val("R3", 2, 1);
    step();
    wr(0, 8'h02); expect_val("R3", 2, 2); expect_val("R4", 0, 32'h7A);
    step();
    // R7
    wr(1, 8'hFF); regSel = 1; expect_val("R7", 0, 32'h02);
    step();
    // R10 with bus-hold bit 1
    busAddr = 16'h1234; busAddrOe = 1; strbIn = 6'h15; strbOeIn = 6'h2A;
    expect_val("R10", 3, 32'h1234); expect_val("R10", 4, 1);
    expect_val("R10", 5, 32'h15); expect_val("R10", 6, 32'h2A);
    step();
    // R9: enter standby with address change in the same cycle
    busAddr = 16'hABCD;
    step();
    swStby = 1; busAddr = 16'h5555;
    expect_val("R9", 3, 32'hABCD); expect_val("R9", 4, 1);
    expect_val("R9", 5, 32'h3F); expect_val("R9", 6, 32'h3F);
    step();
    busAddr = 16'h0F0F; expect_val("R9", 3, 32'hABCD);
    // R6: write during software standby ignored
    wr(0, 8'h81);
    step();
    expect_val("R6", 1, 1); expect_val("R6", 2, 2);
    swStby = 0; regSel = 0;
    expect_val("R6", 0, 32'h7A); expect_val("R10", 3, 32'h0F0F);
    step();
    // R8: bus-hold bit 0
    wr(1, 8'h00);
    swStby = 1; busAddr = 16'h2222;
    expect_val("R8", 4, 0); expect_val("R8", 6, 0);
    step();
    swStby = 0;
    expect_val("R10", 3, 32'h2222); expect_val("R10", 4, 1); expect_val("R10", 6, 32'h2A);
    step();
    // R5: write meets hardware standby
    wr(0, 8'h83); wr(1, 8'h02);
    hwStby = 1; regSel = 0; wrData = 8'h81; wrEn = 1;
    step();
    wrEn = 0; hwStby = 0;
    expect_val("R5", 0, 32'h78); expect_val("R5", 1, 1); expect_val("R5", 2, 0);
    step();
    regSel = 1; expect_val("R5", 0, 32'h00);
    step();
    step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule